// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Asynchronous Serial Transmitter

This block sends asynchronous serial frames that carry nine data bits. Software loads each nine-bit word through a small register port. Bit 8 of the word goes in a high-byte register and bits 7:0 go in a low-byte register. A combined 16-bit view of both registers also exists. Writing the low byte, or the combined view, commits the word to a one-entry buffer. Behind that buffer sits a shift register that software cannot reach. When the shift register is free, the buffered word moves into it, the buffer empties, and a one-cycle transmit-empty request tells software to supply the next word.

The shift register and the buffer work as a pair. If software refills the buffer while a frame is going out, the next frame starts on the cycle after the stop bit ends, with no idle time between the two frames. If the buffer is still empty at that point, the line goes back to idle high and stays there until the next commit. Bit timing comes from an external baud tick. Each bit lasts a parameterised number of ticks, 16 by default.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `tx_o` is 1 and `txi_o` is 0. A read of the combined view (select 2) returns 16'hFFFF, and a read of the high register (select 0) or the low register (select 1) returns 16'h00FF.
- R2: The high register (select 0) stores only `wr_data_i[0]`, which is data bit 8. Its bits 7:1 always read as 1 and writes to them are ignored. An 8-bit register read puts the value on bits 7:0 and zero on bits 15:8.
- R3: A write to select 1 loads the low register from `wr_data_i[7:0]` and marks the buffer full. A write to select 2 loads bit 8 from `wr_data_i[8]` and the low byte from `wr_data_i[7:0]`, ignores `wr_data_i[15:9]`, and marks the buffer full. Select 3 reads as zero, and writes to it have no effect.
- R4: A read of the combined view returns 7'h7F, then the stored bit 8, then the low byte.
- R5: When the buffer is full and the transmitter is idle, the word transfers on the next clock edge. `tx_o` drops to 0 (start bit) in the cycle after that edge.
- R6: A frame is one 0 start bit, then nine data bits with bit 0 first, then one 1 stop bit. Each bit lasts `TICKS_PER_BIT` cycles in which `baud_tick_i` is high. Ticks have no effect while the transmitter is idle.
- R7: If the buffer is full when the last tick of the stop bit arrives, the next start bit follows on the very next cycle, with no idle cycle between frames.
- R8: If the buffer is empty when the stop bit ends, `tx_o` stays 1 until a later commit.
- R9: `txi_o` is high for exactly one cycle: the cycle after each transfer into the shift register, and at no other time.
- R10: A write to the high register alone does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 high, 1 low, 2 combined, 3 none |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the selected register (combinational) |
| baud_tick_i | input | 1 | Bit-time tick enable |
| tx_o | output | 1 | Serial output, idles high |
| txi_o | output | 1 | One-cycle transmit-empty request |

## Verification
The bench aims at the moment the stop bit ends. It refills the buffer in the middle of a frame and expects the next start bit on the following cycle. A design that adds an idle cycle here, or that drops the second word, would differ from the reference on `tx_o`. A write to the high register alone is followed by a long wait. A design that commits on the high-byte write would start a frame early. The bench also writes the combined view with junk in bits 15:9 and reads every register back. This catches a design that keeps the upper high-byte bits or routes data bit 8 from the wrong position. Ticks arrive sometimes every cycle and sometimes sparsely. This exposes a bit timer that counts clocks instead of ticks, or that keeps running while idle.

// File: rtl/uart9_tx_pkg.sv
package uart9_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = DATA_W + 2;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HL   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // stop bit on top, start bit at index 0 so the frame shifts out LSB first
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] word);
    return {1'b1, word, 1'b0};
  endfunction

  function automatic logic [7:0] hi_view(input logic bit8);
    return {7'h7F, bit8};
  endfunction

  function automatic logic [15:0] hl_view(input logic bit8, input logic [7:0] low);
    return {hi_view(bit8), low};
  endfunction
endpackage

// File: rtl/uart9_tx_regs.sv
module uart9_tx_regs
  import uart9_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [15:0]       wr_data_i,
  input  logic              load_evt_i,
  output logic [15:0]       rd_data_o,
  output logic [DATA_W-1:0] buf_word_o,
  output logic              buf_full_o,
  output logic              commit_o
);
  logic       bit8_q;
  logic [7:0] low_q;
  logic       full_q;
  reg_sel_e   sel;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign commit_o = wr_en_i && (sel == SEL_LO || sel == SEL_HL);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bit8_q <= 1'b1;
      low_q  <= 8'hFF;
      full_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (sel)
          SEL_HI: bit8_q <= wr_data_i[0];
          SEL_LO: low_q  <= wr_data_i[7:0];
          SEL_HL: begin
            bit8_q <= wr_data_i[8];
            low_q  <= wr_data_i[7:0];
          end
          default: ;
        endcase
      end
      // a commit in the same cycle as a transfer refills the buffer
      if (commit_o)        full_q <= 1'b1;
      else if (load_evt_i) full_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_HI:  rd_data_o = {8'h00, hi_view(bit8_q)};
      SEL_LO:  rd_data_o = {8'h00, low_q};
      SEL_HL:  rd_data_o = hl_view(bit8_q, low_q);
      default: rd_data_o = 16'h0000;
    endcase
  end

  assign buf_word_o = {bit8_q, low_q};
  assign buf_full_o = full_q;
endmodule

// File: rtl/uart9_tx_shifter.sv
module uart9_tx_shifter
  import uart9_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_word_i,
  output logic              tx_o,
  output logic              load_evt_o,
  output logic              frame_done_o,
  output logic              busy_o
);
  localparam int TCW = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BCW = $clog2(FRAME_W);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TICKS_PER_BIT - 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [TCW-1:0]     tick_q;
  logic [BCW-1:0]     bit_q;
  logic               busy_q;
  logic               bit_end;

  assign bit_end      = busy_q && baud_tick_i && (tick_q == TICK_LAST);
  assign frame_done_o = bit_end && (bit_q == BIT_LAST);
  assign load_evt_o   = buf_full_i && (!busy_q || frame_done_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_evt_o) begin
      shreg_q <= build_frame(buf_word_i);
      tick_q  <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b1;
    end else if (frame_done_o) begin
      shreg_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
    end else if (bit_end) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      tick_q  <= '0;
      bit_q   <= bit_q + 1'b1;
    end else if (busy_q && baud_tick_i) begin
      tick_q  <= tick_q + 1'b1;
    end
  end

  assign tx_o   = shreg_q[0];
  assign busy_o = busy_q;
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic        baud_tick_i,
  output logic        tx_o,
  output logic        txi_o
);
  logic [DATA_W-1:0] buf_word;
  logic              buf_full;
  logic              commit;
  logic              load_evt;
  logic              frame_done;
  logic              busy;
  logic              txi_q;

  uart9_tx_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .reg_sel_i  (reg_sel_i),
    .wr_data_i  (wr_data_i),
    .load_evt_i (load_evt),
    .rd_data_o  (rd_data_o),
    .buf_word_o (buf_word),
    .buf_full_o (buf_full),
    .commit_o   (commit)
  );

  uart9_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_tick_i  (baud_tick_i),
    .buf_full_i   (buf_full),
    .buf_word_i   (buf_word),
    .tx_o         (tx_o),
    .load_evt_o   (load_evt),
    .frame_done_o (frame_done),
    .busy_o       (busy)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) txi_q <= 1'b0;
    else         txi_q <= load_evt;
  end

  assign txi_o = txi_q;
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_o,
  input logic txi_o,
  input logic load_evt,
  input logic frame_done,
  input logic busy,
  input logic buf_full,
  input logic commit
);
  // R9
  txi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txi_o |=> !txi_o);

  // R5
  start_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> (txi_o && !tx_o && busy));

  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);

  // R7
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && buf_full) |=> (busy && !tx_o));

  // R10
  start_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_full && !commit && !busy) |=> !busy);

  // R3
  commit_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> buf_full);
endmodule

bind uart9_tx uart9_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_o       (tx_o),
  .txi_o      (txi_o),
  .load_evt   (load_evt),
  .frame_done (frame_done),
  .busy       (busy),
  .buf_full   (buf_full),
  .commit     (commit)
);

// File: tb/uart9_tx_tb_top.sv
module uart9_tx_tb_top;
  localparam int TPB = 16;
  localparam int FRAME_TICKS = TPB * 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  sel = 2'd2;
  logic [15:0] wdata = 16'h0;
  logic        tick = 1'b0;
  logic [15:0] rdata;
  logic        tx, txi;

  int n_checks = 0;
  int n_fail = 0;
  int tick_period = 3;
  int tick_phase = 0;
  bit finished = 0;

  // reference model state
  bit       m_full, m_hi, m_busy, m_txi;
  bit [7:0] m_lo;
  bit [8:0] m_word;
  int       m_pos;

  always #4 clk = ~clk;

  uart9_tx #(.TICKS_PER_BIT(TPB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .reg_sel_i(sel),
    .wr_data_i(wdata), .rd_data_o(rdata), .baud_tick_i(tick),
    .tx_o(tx), .txi_o(txi));

  always @(posedge clk) begin
    bit ld, ends;
    if (!rst_n) begin
      m_full = 0; m_hi = 1; m_lo = 8'hFF; m_busy = 0; m_txi = 0; m_pos = 0; m_word = '1;
    end else begin
      ends = m_busy && tick && (m_pos == FRAME_TICKS - 1);
      ld = m_full && (!m_busy || ends);
      if (ld) begin
        m_word = {m_hi, m_lo}; m_busy = 1; m_pos = 0;
      end else if (ends) begin
        m_busy = 0;
      end else if (m_busy && tick) begin
        m_pos++;
      end
      m_txi = ld;
      if (ld) m_full = 0;
      if (wr_en) begin
        if (sel == 2'd0) m_hi = wdata[0];
        if (sel == 2'd1) begin m_lo = wdata[7:0]; m_full = 1; end
        if (sel == 2'd2) begin m_hi = wdata[8]; m_lo = wdata[7:0]; m_full = 1; end
      end
    end
  end

  function automatic bit exp_tx();
    int b;
    if (!m_busy) return 1'b1;
    b = m_pos / TPB;
    if (b == 0) return 1'b0;
    if (b == 10) return 1'b1;
    return m_word[b-1];
  endfunction

  function automatic logic [15:0] exp_rd();
    case (sel)
      2'd0: return {8'h00, 7'h7F, m_hi};
      2'd1: return {8'h00, m_lo};
      2'd2: return {7'h7F, m_hi, m_lo};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every cycle, then drive the next inputs
  task automatic step(string tag);
    @(negedge clk);
    if (rst_n) begin
      check({tag, " R6 tx"}, {15'd0, tx}, {15'd0, exp_tx()});
      check("R9 txi", {15'd0, txi}, {15'd0, m_txi});
      check("R4 rdata", rdata, exp_rd());
    end
    wr_en = 1'b0;
    tick_phase++;
    tick = (tick_phase % tick_period) == 0;
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d, string tag);
    step(tag);
    wr_en = 1'b1; sel = s; wdata = d;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sel = 2'd2;
    @(negedge clk);
    check("R1 hl reset", rdata, 16'hFFFF);
    check("R1 tx reset", {15'd0, tx}, 16'd1);
    check("R1 txi reset", {15'd0, txi}, 16'd0);
    sel = 2'd0; #1; check("R1 hi reset", rdata, 16'h00FF);
    sel = 2'd1; #1; check("R1 lo reset", rdata, 16'h00FF);
    sel = 2'd3; #1; check("R3 none read", rdata, 16'h0000);
    // R2 / R10: high byte write only, no frame
    wr(2'd0, 16'hABFE, "R2");
    wr(2'd3, 16'h1234, "R3");
    step("R10"); sel = 2'd0;
    run(60, "R10");
    check("R2 hi readback", rdata, 16'h00FE);
    check("R10 still idle", {15'd0, tx}, 16'd1);
    // R5: low-byte commit starts frame
    wr(2'd1, 16'h00A5, "R5");
    run(200, "R6");
    // R7: refill mid-frame, back-to-back
    wr(2'd0, 16'h0001, "R7");
    wr(2'd1, 16'h003C, "R7");
    sel = 2'd2;
    run(FRAME_TICKS * 3 + 60, "R7");
    run(FRAME_TICKS * 3 + 40, "R8");
    check("R8 idle after drain", {15'd0, tx}, 16'd1);
    // R3: combined write with junk high bits, ticks every cycle
    tick_period = 1;
    wr(2'd2, 16'hFF55, "R3");
    step("R3"); sel = 2'd2;
    #1; check("R3 hl readback", rdata, 16'hFF55);
    run(20, "R6");
    wr(2'd2, 16'h0100, "R7");
    run(FRAME_TICKS * 2 + 40, "R7");
    // sparse ticks, data bit 8 zero
    tick_period = 5;
    wr(2'd2, 16'hFEFF, "R6");
    run(FRAME_TICKS * 5 + 50, "R6");
    check("R8 final idle", {15'd0, tx}, 16'd1);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule